// File: doc/BRIEF.md
# Banked General Register File with Status Word

This block holds the architectural registers of a 16-bit minicomputer-style processor core. It has two banks of six general registers, one program counter that both banks share, and three stack-pointer slots: one each for kernel, supervisor and user mode. The processor status word (PSW) lives here as separate fields. The PSW picks the active bank and decides which stack-pointer slot the stack-pointer register number (6) reaches.

The core talks to the block through three ports:

- **CPU register port.** One combinational read and one clocked write, each addressed by a 3-bit register number.
- **PSW port.** A full-word load of the status word, plus a narrow path that updates only the four condition-code bits coming from the ALU.
- **Bus-side window.** Reaches all sixteen physical slots directly. The bus presents the offset from the window base, so 0 to 15 correspond to bus locations 0o17700 to 0o17717. Every offset is valid, odd ones included, so a debugger or a console can inspect and patch any register regardless of the current mode or bank.

Decode, address translation and arithmetic sit outside the block.

Top module: `bankedRegFile`

## Requirements
- R1: After reset all sixteen register slots read zero. The PSW reads 0x00E0: kernel current mode, kernel previous mode, bank 0, priority 7, trace 0 and condition codes 0. `pswFault` is low.
- R2: The PSW packs as follows:
  - bits 15:14 current mode (kernel 00, supervisor 01, user 11)
  - bits 13:12 previous mode
  - bit 11 bank select
  - bits 7:5 priority
  - bit 4 trace
  - bits 3:0 N, Z, V, C

  An accepted PSW write reads back as the written value with bits 10:8 forced to zero.
- R3: A PSW write whose current-mode or previous-mode field equals 10 raises `pswFault` combinationally in that cycle. The PSW is left unchanged.
- R4: When `ccWrEn` is high, PSW bits 3:0 load `ccIn` at the clock edge, unless an accepted PSW write occurs in the same cycle; in that case the PSW write wins.
- R5: CPU register numbers 0 to 5 reach bank 0 when PSW bit 11 is 0 and bank 1 when it is 1. The banks are independent storage.
- R6: CPU register number 7 is one shared PC. A write to it in either bank shows at window offset 7, and reads back under either bank.
- R7: CPU register number 6 reaches the stack-pointer slot of the current mode: kernel is window offset 6, supervisor is offset 14 and user is offset 15.
- R8: The window maps its offsets as follows:
  - 0 to 5: bank 0 registers 0 to 5
  - 6: kernel SP
  - 7: PC
  - 8 to 13: bank 1 registers 0 to 5
  - 14: supervisor SP
  - 15: user SP

  Window reads are combinational. Window writes take effect at the clock edge.
- R9: A window write to the stack-pointer slot of the current mode is seen through CPU register number 6 from the next cycle on, exactly like a CPU write to register 6.
- R10: If a CPU write and a window write target the same physical slot in one cycle, the CPU data is stored.
- R11: A PSW write needs no privilege. It changes the bank and stack-pointer mapping from the next cycle on. A CPU write issued in the same cycle as a PSW write still uses the old mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuRdAddr | input | 3 | CPU read register number |
| cpuRdData | output | 16 | CPU read data (combinational) |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuWrAddr | input | 3 | CPU write register number |
| cpuWrData | input | 16 | CPU write data |
| pswWrEn | input | 1 | Full PSW load strobe |
| pswWrData | input | 16 | PSW load value |
| pswRdData | output | 16 | Packed PSW |
| pswFault | output | 1 | Rejected PSW load (reserved mode) |
| ccWrEn | input | 1 | Condition-code update strobe |
| ccIn | input | 4 | N, Z, V, C from the ALU |
| winEn | input | 1 | Window access select |
| winWrEn | input | 1 | Window write (with winEn) |
| winAddr | input | 4 | Window offset 0 to 15 |
| winWrData | input | 16 | Window write data |
| winRdData | output | 16 | Window read data (combinational) |

## Verification
The hardest situation to reach is a collision on the stack pointer of a non-kernel mode. In that case a CPU write through register 6 and a window write land on the same slot, or a PSW load swaps the mapping in the very cycle a register-6 write is issued. Random stimulus rarely lines up the mode, the register number and the window offset at once. Directed sequences therefore first move the PSW into user mode, then issue the colliding writes, and then read the slot back through both the window and register 6. A reference model in the bench follows every random cycle, so bank and mode switches driven by random PSW loads are covered across all slots.

// File: rtl/brfPkg.sv
package brfPkg;
  localparam int NumSlots = 16;
  localparam int SlotIdxW = $clog2(NumSlots);
  localparam int PswW = 16;

  typedef enum logic [1:0] {
    MODE_K   = 2'b00,
    MODE_S   = 2'b01,
    MODE_BAD = 2'b10,
    MODE_U   = 2'b11
  } modeT;

  typedef struct packed {
    logic [NumSlots-1:0] cpuWe;
    logic [NumSlots-1:0] winWe;
    logic                pswLoad;
    logic                ccLoad;
    logic [SlotIdxW-1:0] cpuRdIdx;
  } strobeT;

  // physical slot reached by a CPU register number
  function automatic logic [SlotIdxW-1:0] slotOf(logic [2:0] regNum, logic bankSel, modeT mode);
    if (regNum == 3'd7) return SlotIdxW'(7);
    if (regNum == 3'd6) begin
      case (mode)
        MODE_S:  return SlotIdxW'(14);
        MODE_U:  return SlotIdxW'(15);
        default: return SlotIdxW'(6);
      endcase
    end
    return {bankSel, regNum};
  endfunction
endpackage

// File: rtl/regCtrl.sv
module regCtrl
  import brfPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          cpuRdAddr,
  input  logic                cpuWrEn,
  input  logic [2:0]          cpuWrAddr,
  input  logic                pswWrEn,
  input  logic [3:0]          pswModeBits,
  input  logic                ccWrEn,
  input  logic                winEn,
  input  logic                winWrEn,
  input  logic [SlotIdxW-1:0] winAddr,
  input  modeT                curMode,
  input  logic                regSet,
  output strobeT              str,
  output logic                pswFault
);
  logic pswLegal;
  logic [SlotIdxW-1:0] cpuWrIdx;

  always_comb begin
    pswLegal = (pswModeBits[3:2] != MODE_BAD) && (pswModeBits[1:0] != MODE_BAD);
    pswFault = pswWrEn && !pswLegal;
    cpuWrIdx = slotOf(cpuWrAddr, regSet, curMode);
  end

  assign str.pswLoad  = pswWrEn && pswLegal;
  assign str.ccLoad   = ccWrEn && !str.pswLoad;
  assign str.cpuRdIdx = slotOf(cpuRdAddr, regSet, curMode);

  for (genvar i = 0; i < NumSlots; i++) begin : g_we
    assign str.cpuWe[i] = cpuWrEn && (cpuWrIdx == SlotIdxW'(i));
    assign str.winWe[i] = winEn && winWrEn && (winAddr == SlotIdxW'(i)) && !str.cpuWe[i];
  end

  // R10
  cpu_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(str.cpuWe));

  // R7
  user_sp_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && cpuWrAddr == 3'd6 && curMode == MODE_U) |-> str.cpuWe[15]);
endmodule

// File: rtl/regDatapath.sv
module regDatapath
  import brfPkg::*;
#(
  parameter int DataW = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              str,
  input  logic [DataW-1:0]    cpuWrData,
  input  logic [DataW-1:0]    winWrData,
  input  logic [PswW-1:0]     pswWrData,
  input  logic [3:0]          ccIn,
  input  logic [SlotIdxW-1:0] winAddr,
  output logic [DataW-1:0]    cpuRdData,
  output logic [DataW-1:0]    winRdData,
  output logic [PswW-1:0]     pswRdData,
  output modeT                curMode,
  output logic                regSet
);
  logic [DataW-1:0] slots [NumSlots];
  modeT       prevMode;
  logic [2:0] prio;
  logic       trace;
  logic [3:0] cc;

  for (genvar i = 0; i < NumSlots; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN)               slots[i] <= '0;
      else if (str.cpuWe[i])   slots[i] <= cpuWrData;
      else if (str.winWe[i])   slots[i] <= winWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMode  <= MODE_K;
      prevMode <= MODE_K;
      regSet   <= 1'b0;
      prio     <= 3'd7;
      trace    <= 1'b0;
      cc       <= 4'd0;
    end else if (str.pswLoad) begin
      curMode  <= modeT'(pswWrData[15:14]);
      prevMode <= modeT'(pswWrData[13:12]);
      regSet   <= pswWrData[11];
      prio     <= pswWrData[7:5];
      trace    <= pswWrData[4];
      cc       <= pswWrData[3:0];
    end else if (str.ccLoad) begin
      cc <= ccIn;
    end
  end

  assign pswRdData = {curMode, prevMode, regSet, 3'b000, prio, trace, cc};
  assign cpuRdData = slots[str.cpuRdIdx];
  assign winRdData = slots[winAddr];

  // R6
  pc_shared_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.cpuWe[7] |=> slots[7] == $past(cpuWrData));

  // R11
  mode_switch_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.pswLoad |=> pswRdData[15:11] == $past(pswWrData[15:11]));

  // R4
  cc_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.ccLoad |=> pswRdData[3:0] == $past(ccIn));
endmodule

// File: rtl/bankedRegFile.sv
module bankedRegFile
  import brfPkg::*;
#(
  parameter int DataW = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          cpuRdAddr,
  output logic [DataW-1:0]    cpuRdData,
  input  logic                cpuWrEn,
  input  logic [2:0]          cpuWrAddr,
  input  logic [DataW-1:0]    cpuWrData,
  input  logic                pswWrEn,
  input  logic [PswW-1:0]     pswWrData,
  output logic [PswW-1:0]     pswRdData,
  output logic                pswFault,
  input  logic                ccWrEn,
  input  logic [3:0]          ccIn,
  input  logic                winEn,
  input  logic                winWrEn,
  input  logic [SlotIdxW-1:0] winAddr,
  input  logic [DataW-1:0]    winWrData,
  output logic [DataW-1:0]    winRdData
);
  strobeT str;
  modeT   curMode;
  logic   regSet;

  regCtrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuRdAddr(cpuRdAddr), .cpuWrEn(cpuWrEn), .cpuWrAddr(cpuWrAddr),
    .pswWrEn(pswWrEn), .pswModeBits(pswWrData[15:12]),
    .ccWrEn(ccWrEn), .winEn(winEn), .winWrEn(winWrEn), .winAddr(winAddr),
    .curMode(curMode), .regSet(regSet),
    .str(str), .pswFault(pswFault)
  );

  regDatapath #(.DataW(DataW)) u_dp (
    .clk(clk), .rstN(rstN), .str(str),
    .cpuWrData(cpuWrData), .winWrData(winWrData),
    .pswWrData(pswWrData), .ccIn(ccIn), .winAddr(winAddr),
    .cpuRdData(cpuRdData), .winRdData(winRdData), .pswRdData(pswRdData),
    .curMode(curMode), .regSet(regSet)
  );

  // R3
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pswFault && !ccWrEn) |=> $stable(pswRdData));
endmodule

// File: tb/bankedRegFile_tb.sv
module bankedRegFile_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cpuRdAddr = '0;
  logic [15:0] cpuRdData;
  logic        cpuWrEn = 1'b0;
  logic [2:0]  cpuWrAddr = '0;
  logic [15:0] cpuWrData = '0;
  logic        pswWrEn = 1'b0;
  logic [15:0] pswWrData = '0;
  logic [15:0] pswRdData;
  logic        pswFault;
  logic        ccWrEn = 1'b0;
  logic [3:0]  ccIn = '0;
  logic        winEn = 1'b0;
  logic        winWrEn = 1'b0;
  logic [3:0]  winAddr = '0;
  logic [15:0] winWrData = '0;
  logic [15:0] winRdData;

  int errCount = 0;
  int chkCount = 0;
  bit finished = 0;

  logic [15:0] mSlot [16];
  logic [15:0] mPsw;

  always #5 clk = ~clk;

  bankedRegFile u_dut (.*);

  function automatic logic [3:0] mapReg(logic [2:0] r, logic [15:0] psw);
    if (r == 3'd7) return 4'd7;
    if (r == 3'd6) begin
      if (psw[15:14] == 2'b01) return 4'd14;
      if (psw[15:14] == 2'b11) return 4'd15;
      return 4'd6;
    end
    return {psw[11], r};
  endfunction

  function automatic bit badPsw(logic [15:0] v);
    return (v[15:14] == 2'b10) || (v[13:12] == 2'b10);
  endfunction

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    chkCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic readChk(logic [2:0] ca, logic [3:0] wa, string tag);
    cpuRdAddr = ca;
    winAddr   = wa;
    #1;
    check(tag, "cpuRd", cpuRdData, mSlot[mapReg(ca, mPsw)]);
    check(tag, "winRd", winRdData, mSlot[wa]);
    check(tag, "psw", pswRdData, mPsw);
  endtask

  task automatic doCycle(bit cw, logic [2:0] ca, logic [15:0] cd,
                         bit ww, logic [3:0] wa, logic [15:0] wd,
                         bit pw, logic [15:0] pd, bit cwe, logic [3:0] cv);
    cpuWrEn = cw; cpuWrAddr = ca; cpuWrData = cd;
    winEn = ww; winWrEn = ww; winAddr = wa; winWrData = wd;
    pswWrEn = pw; pswWrData = pd; ccWrEn = cwe; ccIn = cv;
    #1;
    check("R3", "fault", {15'd0, pswFault}, {15'd0, pw && badPsw(pd)});
    @(posedge clk);
    if (ww) mSlot[wa] = wd;
    if (cw) mSlot[mapReg(ca, mPsw)] = cd;
    if (pw && !badPsw(pd)) mPsw = pd & 16'hF8FF;
    else if (cwe) mPsw[3:0] = cv;
    @(negedge clk);
    cpuWrEn = 0; winEn = 0; winWrEn = 0; pswWrEn = 0; ccWrEn = 0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errCount++;
      chkCount++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errCount, chkCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    foreach (mSlot[i]) mSlot[i] = '0;
    mPsw = 16'h00E0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int i = 0; i < 16; i++) readChk(3'(i % 8), 4'(i), "R1");
    check("R1", "fault", {15'd0, pswFault}, 16'd0);

    // R9 window write to user SP, then read through register 6
    doCycle(0, 0, 0, 0, 0, 0, 1, 16'hC000, 0, 0);
    doCycle(0, 0, 0, 1, 4'd15, 16'h1234, 0, 0, 0, 0);
    readChk(3'd6, 4'd15, "R9");
    check("R9", "r6", cpuRdData, 16'h1234);
    // R10 collision on user SP
    doCycle(1, 3'd6, 16'hAAAA, 1, 4'd15, 16'h5555, 0, 0, 0, 0);
    readChk(3'd6, 4'd15, "R10");
    check("R10", "winSp", winRdData, 16'hAAAA);
    // R11 same-cycle PSW load and register-6 write use the old mapping
    doCycle(1, 3'd6, 16'h7777, 0, 0, 0, 1, 16'h0000, 0, 0);
    readChk(3'd6, 4'd15, "R11");
    check("R11", "oldSp", winRdData, 16'h7777);
    check("R11", "kSp", cpuRdData, 16'h0000);
    // R7 supervisor SP slot
    doCycle(0, 0, 0, 0, 0, 0, 1, 16'h4000, 0, 0);
    doCycle(1, 3'd6, 16'h3333, 0, 0, 0, 0, 0, 0, 0);
    readChk(3'd6, 4'd14, "R7");
    check("R7", "supSp", winRdData, 16'h3333);
    // R4 PSW load beats condition-code update
    doCycle(0, 0, 0, 0, 0, 0, 1, 16'h0003, 1, 4'hF);
    readChk(3'd0, 4'd0, "R4");
    check("R4", "pswWins", pswRdData, 16'h0003);
    doCycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 4'hA);
    readChk(3'd0, 4'd0, "R4");
    check("R4", "ccOnly", pswRdData, 16'h000A);
    // R3 reserved mode rejected
    doCycle(0, 0, 0, 0, 0, 0, 1, 16'h8000, 0, 0);
    readChk(3'd0, 4'd0, "R3");
    check("R3", "pswKept", pswRdData, 16'h000A);
    // R2 reserved bits 10:8 read zero
    doCycle(0, 0, 0, 0, 0, 0, 1, 16'h5FFF, 0, 0);
    readChk(3'd0, 4'd0, "R2");
    check("R2", "pack", pswRdData, 16'h58FF);
    // R5 / R6 bank 1 register and shared PC
    doCycle(0, 0, 0, 0, 0, 0, 1, 16'h0800, 0, 0);
    doCycle(1, 3'd2, 16'h2222, 0, 0, 0, 0, 0, 0, 0);
    readChk(3'd2, 4'd10, "R5");
    check("R5", "bank1", winRdData, 16'h2222);
    readChk(3'd2, 4'd2, "R5");
    check("R5", "bank0", winRdData, 16'h0000);
    doCycle(1, 3'd7, 16'h4444, 0, 0, 0, 0, 0, 0, 0);
    doCycle(0, 0, 0, 0, 0, 0, 1, 16'h0000, 0, 0);
    readChk(3'd7, 4'd7, "R6");
    check("R6", "pc", cpuRdData, 16'h4444);

    // R8 random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      doCycle($urandom_range(0, 1), 3'($urandom), 16'($urandom),
              $urandom_range(0, 1), 4'($urandom), 16'($urandom),
              ($urandom_range(0, 7) == 0), 16'($urandom),
              $urandom_range(0, 1), 4'($urandom));
      readChk(3'($urandom), 4'($urandom), "R8");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end
endmodule